// File: doc/BRIEF.md
# Event-Paced Receive DMA Channel

This block is one DMA channel that copies received data from a peripheral into a ring buffer in memory. Each pulse on the event input moves one element of a programmable byte size. The block issues that element as a single request on a simple memory write port, with per-byte strobes, and holds the request until the memory acknowledges it. Software programs the element size, the elements per frame, the frame count, the current destination and the ring bounds through a small register port. The destination wraps to the ring base whenever the next address would reach the ring end.

The destination and remaining-count registers change as soon as a request is issued, which is before the data has reached memory. For that reason, completion is reported only from the write acknowledge. An acknowledged element that is not the last one raises the intermediate completion count when its enable is set. The last element of the last frame raises the final completion count when its enable is set. Both counts are sticky, saturate, and are cleared by writing ones, so completions that occur while the CPU has interrupts masked are still recorded. A separate landed-element counter tells software exactly how many elements have arrived. An event that comes while a write is still outstanding waits in a one-element queue. An event that comes while the queue is full sets a sticky missed flag.

Top module: `evdma_channel`

## Requirements
- R1: After reset, no write request is pending, the interrupt is low, the status and landed registers read zero, the element size reads 1, and the destination and element count read zero.
- R2: An accepted event produces a write request in the next cycle. The request carries the destination address held before the event and the full captured event word. The strobe has its low N bits set, where N is the element size. The request stays stable until the cycle in which the acknowledge is high.
- R3: When a request is issued, the destination (register 4) advances by the element size and the remaining element count (register 2) drops by one. Both changes happen before the acknowledge.
- R4: If the advanced destination would be greater than or equal to ring end (register 6), the destination becomes the ring base (register 5).
- R5: Status bits [PEND_W-1:0] hold the intermediate completion count. It rises by one on the acknowledge of any element other than the final one, only when option bit 0 is set. It saturates at its maximum value and never changes on issue alone.
- R6: Status bits [2*PEND_W-1:PEND_W] hold the final completion count. It rises by one on the acknowledge of the last element of the last frame, only when option bit 1 is set.
- R7: When the element count reaches zero while the frame count (register 3) is above 1, the element count reloads the value last written to register 2 and the frame count drops by one. That element counts as intermediate, not final.
- R8: Register 8 counts acknowledged elements. Any write to register 8 clears it.
- R9: An event that arrives while a write is outstanding and the queue is empty is held in the queue. Its request appears in the cycle after the acknowledge of the outstanding write.
- R10: An event that arrives while a write is outstanding, the queue is full and elements remain unclaimed sets status bit 2*PEND_W. That event is dropped.
- R11: An event that arrives while no element remains unclaimed (count zero and frame count not above 1) is ignored. It causes no request, no address change and no missed flag.
- R12: A write to status register 7 clears the intermediate count when data bit 0 is set, the final count when bit 1 is set, and the missed flag when bit 2 is set. Fields whose bit is zero are kept.
- R13: The interrupt is high when the intermediate count is nonzero with option bit 0 set, or when the final count is nonzero with option bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 1 | Peripheral receive event, one pulse per element |
| ev_data_i | input | 8*ELEM_BYTES | Peripheral receive word, sampled with the event |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | ADDR_W | Register write data |
| cfg_rdata_o | output | ADDR_W | Register read data for cfg_addr_i, combinational |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | ADDR_W | Memory write byte address |
| wr_data_o | output | 8*ELEM_BYTES | Memory write data, element in the low bytes |
| wr_strb_o | output | ELEM_BYTES | Byte strobes |
| wr_ack_i | input | 1 | Memory write acknowledge |
| irq_o | output | 1 | Completion interrupt |

## Verification
The write request, the new destination and the new count all appear after the clock edge that samples the event. The completion counts, the landed count and the interrupt change after the edge that samples the acknowledge. A queued element's request follows the acknowledge edge in the next cycle. The bench drives every input on a falling edge and reads outputs and registers just after the next falling edge, so each check lands one edge after its cause. A readback taken between issue and acknowledge shows that the address has moved while the completion flags have not.

// File: rtl/evdma_pkg.sv
package evdma_pkg;
   typedef enum logic [3:0] {
      REG_OPT    = 4'd0,
      REG_SIZE   = 4'd1,
      REG_COUNT  = 4'd2,
      REG_FRAMES = 4'd3,
      REG_DEST   = 4'd4,
      REG_RBASE  = 4'd5,
      REG_REND   = 4'd6,
      REG_STAT   = 4'd7,
      REG_LANDED = 4'd8
   } reg_sel_e;

   localparam int CLR_MID_BIT  = 0;
   localparam int CLR_FIN_BIT  = 1;
   localparam int CLR_MISS_BIT = 2;
endpackage

// File: rtl/evdma_regs.sv
module evdma_regs
   import evdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3,
   parameter int CNT_W  = 16,
   parameter int STAT_W = 9,
   parameter int LAND_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [3:0]        cfg_addr_i,
   input  logic [ADDR_W-1:0] cfg_wdata_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  frames_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [LAND_W-1:0] landed_i,
   output logic              mid_en_o,
   output logic              fin_en_o,
   output logic [SIZE_W-1:0] size_o,
   output logic [ADDR_W-1:0] ring_base_o,
   output logic [ADDR_W-1:0] ring_end_o,
   output logic [ADDR_W-1:0] cfg_rdata_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mid_en_o    <= 1'b0;
         fin_en_o    <= 1'b0;
         size_o      <= SIZE_W'(1);
         ring_base_o <= '0;
         ring_end_o  <= '0;
      end else if (cfg_we_i) begin
         case (cfg_addr_i)
            REG_OPT:   {fin_en_o, mid_en_o} <= cfg_wdata_i[1:0];
            REG_SIZE:  size_o      <= cfg_wdata_i[SIZE_W-1:0];
            REG_RBASE: ring_base_o <= cfg_wdata_i;
            REG_REND:  ring_end_o  <= cfg_wdata_i;
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata_o = '0;
      case (cfg_addr_i)
         REG_OPT:    cfg_rdata_o = ADDR_W'({fin_en_o, mid_en_o});
         REG_SIZE:   cfg_rdata_o = ADDR_W'(size_o);
         REG_COUNT:  cfg_rdata_o = ADDR_W'(cnt_i);
         REG_FRAMES: cfg_rdata_o = ADDR_W'(frames_i);
         REG_DEST:   cfg_rdata_o = dst_i;
         REG_RBASE:  cfg_rdata_o = ring_base_o;
         REG_REND:   cfg_rdata_o = ring_end_o;
         REG_STAT:   cfg_rdata_o = ADDR_W'(stat_i);
         REG_LANDED: cfg_rdata_o = ADDR_W'(landed_i);
         default:    cfg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/evdma_xfer.sv
module evdma_xfer
   import evdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int ELEM_BYTES = 4,
   parameter int SIZE_W     = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ev_i,
   input  logic [8*ELEM_BYTES-1:0] ev_data_i,
   input  logic                    cfg_we_i,
   input  logic [3:0]              cfg_addr_i,
   input  logic [ADDR_W-1:0]       cfg_wdata_i,
   input  logic [SIZE_W-1:0]       size_i,
   input  logic [ADDR_W-1:0]       ring_base_i,
   input  logic [ADDR_W-1:0]       ring_end_i,
   input  logic                    wr_ack_i,
   output logic                    wr_req_o,
   output logic [ADDR_W-1:0]       wr_addr_o,
   output logic [8*ELEM_BYTES-1:0] wr_data_o,
   output logic [ELEM_BYTES-1:0]   wr_strb_o,
   output logic [ADDR_W-1:0]       dst_o,
   output logic [CNT_W-1:0]        cnt_o,
   output logic [CNT_W-1:0]        frames_o,
   output logic                    land_o,
   output logic                    land_final_o,
   output logic                    miss_o
);
   localparam int DW = 8 * ELEM_BYTES;

   logic              q_valid_q;
   logic [DW-1:0]     q_data_q;
   logic [CNT_W-1:0]  reload_q;
   logic [ELEM_BYTES-1:0] strb_nxt;
   logic              ack, slot_free, ev_ok, issue_q, issue_ev, issue, enq;
   logic [ADDR_W:0]   dst_sum;
   logic [ADDR_W-1:0] dst_nxt;

   for (genvar b = 0; b < ELEM_BYTES; b++) begin : g_strb
      assign strb_nxt[b] = (size_i > SIZE_W'(b));
   end

   assign ack       = wr_req_o && wr_ack_i;
   assign slot_free = !wr_req_o || wr_ack_i;
   assign ev_ok     = ev_i && ((cnt_o > CNT_W'(q_valid_q)) || (frames_o > CNT_W'(1)));
   assign issue_q   = slot_free && q_valid_q;
   assign issue_ev  = slot_free && !q_valid_q && ev_ok;
   assign issue     = issue_q || issue_ev;
   assign enq       = ev_ok && !issue_ev && (!q_valid_q || issue_q);
   assign miss_o    = ev_ok && q_valid_q && !issue_q;
   assign land_o    = ack;

   assign dst_sum = (ADDR_W+1)'(dst_o) + (ADDR_W+1)'(size_i);
   assign dst_nxt = (dst_sum >= (ADDR_W+1)'(ring_end_i)) ? ring_base_i : dst_sum[ADDR_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_req_o     <= 1'b0;
         wr_addr_o    <= '0;
         wr_data_o    <= '0;
         wr_strb_o    <= '0;
         land_final_o <= 1'b0;
         q_valid_q    <= 1'b0;
         q_data_q     <= '0;
         dst_o        <= '0;
         cnt_o        <= '0;
         reload_q     <= '0;
         frames_o     <= '0;
      end else begin
         if (issue) begin
            wr_req_o  <= 1'b1;
            wr_addr_o <= dst_o;
            wr_data_o <= q_valid_q ? q_data_q : ev_data_i;
            wr_strb_o <= strb_nxt;
            dst_o     <= dst_nxt;
            if (cnt_o == CNT_W'(1)) begin
               if (frames_o > CNT_W'(1)) begin
                  cnt_o        <= reload_q;
                  frames_o     <= frames_o - 1'b1;
                  land_final_o <= 1'b0;
               end else begin
                  cnt_o        <= '0;
                  land_final_o <= 1'b1;
               end
            end else begin
               cnt_o        <= cnt_o - 1'b1;
               land_final_o <= 1'b0;
            end
         end else if (ack) begin
            wr_req_o <= 1'b0;
         end

         if (enq) begin
            q_valid_q <= 1'b1;
            q_data_q  <= ev_data_i;
         end else if (issue_q) begin
            q_valid_q <= 1'b0;
         end

         if (cfg_we_i) begin
            case (cfg_addr_i)
               REG_COUNT: begin
                  cnt_o    <= cfg_wdata_i[CNT_W-1:0];
                  reload_q <= cfg_wdata_i[CNT_W-1:0];
               end
               REG_FRAMES: frames_o <= cfg_wdata_i[CNT_W-1:0];
               REG_DEST:   dst_o    <= cfg_wdata_i;
               default: ;
            endcase
         end
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_strb_o));

   assert_miss_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss_o |-> q_valid_q && wr_req_o && !wr_ack_i);

   assert_idle_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_req_o && !q_valid_q && cnt_o == '0 && frames_o <= CNT_W'(1) |=> !wr_req_o);

   assert_queue_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_valid_q && ack |=> wr_req_o);
endmodule

// File: rtl/evdma_cmpl.sv
module evdma_cmpl #(
   parameter int PEND_W   = 4,
   parameter int LAND_W   = 16,
   parameter bit PEND_SAT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              land_i,
   input  logic              land_final_i,
   input  logic              mid_en_i,
   input  logic              fin_en_i,
   input  logic              miss_i,
   input  logic              clr_mid_i,
   input  logic              clr_fin_i,
   input  logic              clr_miss_i,
   input  logic              clr_landed_i,
   output logic [PEND_W-1:0] mid_o,
   output logic [PEND_W-1:0] fin_o,
   output logic              missed_o,
   output logic [LAND_W-1:0] landed_o,
   output logic              irq_o
);
   logic              mid_inc, fin_inc;
   logic [PEND_W-1:0] mid_base, fin_base, mid_nxt, fin_nxt;

   assign mid_inc  = land_i && !land_final_i && mid_en_i;
   assign fin_inc  = land_i && land_final_i && fin_en_i;
   assign mid_base = clr_mid_i ? '0 : mid_o;
   assign fin_base = clr_fin_i ? '0 : fin_o;

   if (PEND_SAT) begin : g_sat
      assign mid_nxt = (mid_inc && !(&mid_base)) ? mid_base + 1'b1 : mid_base;
      assign fin_nxt = (fin_inc && !(&fin_base)) ? fin_base + 1'b1 : fin_base;
   end else begin : g_wrap
      assign mid_nxt = mid_inc ? mid_base + 1'b1 : mid_base;
      assign fin_nxt = fin_inc ? fin_base + 1'b1 : fin_base;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mid_o    <= '0;
         fin_o    <= '0;
         missed_o <= 1'b0;
         landed_o <= '0;
      end else begin
         mid_o    <= mid_nxt;
         fin_o    <= fin_nxt;
         missed_o <= miss_i || (missed_o && !clr_miss_i);
         if (clr_landed_i) landed_o <= LAND_W'(land_i);
         else if (land_i)  landed_o <= landed_o + 1'b1;
      end
   end

   assign irq_o = (mid_en_i && (mid_o != '0)) || (fin_en_i && (fin_o != '0));

   assert_landed_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      land_i && !clr_landed_i |=> landed_o == LAND_W'($past(landed_o) + 1'b1));

   assert_mid_only_on_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !land_i && !clr_mid_i |=> $stable(mid_o));

   assert_fin_only_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !land_i && !clr_fin_i |=> $stable(fin_o));

   assert_miss_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      missed_o && !clr_miss_i |=> missed_o);
endmodule

// File: rtl/evdma_channel.sv
module evdma_channel
   import evdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int ELEM_BYTES = 4,
   parameter int PEND_W     = 4,
   parameter int LAND_W     = 16,
   parameter bit PEND_SAT   = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ev_i,
   input  logic [8*ELEM_BYTES-1:0] ev_data_i,
   input  logic                    cfg_we_i,
   input  logic [3:0]              cfg_addr_i,
   input  logic [ADDR_W-1:0]       cfg_wdata_i,
   output logic [ADDR_W-1:0]       cfg_rdata_o,
   output logic                    wr_req_o,
   output logic [ADDR_W-1:0]       wr_addr_o,
   output logic [8*ELEM_BYTES-1:0] wr_data_o,
   output logic [ELEM_BYTES-1:0]   wr_strb_o,
   input  logic                    wr_ack_i,
   output logic                    irq_o
);
   localparam int SIZE_W = $clog2(ELEM_BYTES + 1);
   localparam int STAT_W = 2 * PEND_W + 1;

   if (ELEM_BYTES < 1) begin : g_bad_elem
      $error("ELEM_BYTES must be at least 1");
   end
   if (CNT_W > ADDR_W || LAND_W > ADDR_W || STAT_W > ADDR_W || SIZE_W > ADDR_W) begin : g_bad_width
      $error("register fields must fit in ADDR_W");
   end
   if (PEND_W < 1 || CNT_W < 2) begin : g_bad_cnt
      $error("PEND_W and CNT_W too small");
   end

   logic              mid_en, fin_en, land, land_final, miss, missed;
   logic [SIZE_W-1:0] size;
   logic [ADDR_W-1:0] ring_base, ring_end, dst;
   logic [CNT_W-1:0]  cnt, frames;
   logic [PEND_W-1:0] mid_cnt, fin_cnt;
   logic [LAND_W-1:0] landed;
   logic              stat_we, clr_landed;

   assign stat_we    = cfg_we_i && (cfg_addr_i == REG_STAT);
   assign clr_landed = cfg_we_i && (cfg_addr_i == REG_LANDED);

   evdma_regs #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .STAT_W(STAT_W), .LAND_W(LAND_W)
   ) u_regs (
      .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
      .dst_i(dst), .cnt_i(cnt), .frames_i(frames),
      .stat_i({missed, fin_cnt, mid_cnt}), .landed_i(landed),
      .mid_en_o(mid_en), .fin_en_o(fin_en), .size_o(size),
      .ring_base_o(ring_base), .ring_end_o(ring_end), .cfg_rdata_o
   );

   evdma_xfer #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ELEM_BYTES(ELEM_BYTES), .SIZE_W(SIZE_W)
   ) u_xfer (
      .clk_i, .rst_ni, .ev_i, .ev_data_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
      .size_i(size), .ring_base_i(ring_base), .ring_end_i(ring_end), .wr_ack_i,
      .wr_req_o, .wr_addr_o, .wr_data_o, .wr_strb_o,
      .dst_o(dst), .cnt_o(cnt), .frames_o(frames),
      .land_o(land), .land_final_o(land_final), .miss_o(miss)
   );

   evdma_cmpl #(
      .PEND_W(PEND_W), .LAND_W(LAND_W), .PEND_SAT(PEND_SAT)
   ) u_cmpl (
      .clk_i, .rst_ni, .land_i(land), .land_final_i(land_final),
      .mid_en_i(mid_en), .fin_en_i(fin_en), .miss_i(miss),
      .clr_mid_i(stat_we && cfg_wdata_i[CLR_MID_BIT]),
      .clr_fin_i(stat_we && cfg_wdata_i[CLR_FIN_BIT]),
      .clr_miss_i(stat_we && cfg_wdata_i[CLR_MISS_BIT]),
      .clr_landed_i(clr_landed),
      .mid_o(mid_cnt), .fin_o(fin_cnt), .missed_o(missed), .landed_o(landed), .irq_o
   );

   assert_irq_source_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (mid_en && mid_cnt != '0) || (fin_en && fin_cnt != '0));
endmodule

// File: tb/evdma_channel_tb_top.sv
module evdma_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev = 1'b0;
   logic [31:0] ev_data = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        wr_req;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  wr_strb;
   logic        wr_ack = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   evdma_channel dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .ev_data_i(ev_data),
      .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_strb_o(wr_strb), .wr_ack_i(wr_ack), .irq_o(irq)
   );

   typedef struct packed {
      logic [31:0] data;
      logic [3:0]  dly;
      logic [31:0] addr;
      logic [31:0] dst;
      logic [3:0]  mid;
      logic [3:0]  fin;
      logic [15:0] cnt;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{32'h000000A1, 4'd0, 32'h100, 32'h101, 4'd1, 4'd0, 16'd3},
      '{32'h000000B2, 4'd2, 32'h101, 32'h102, 4'd2, 4'd0, 16'd2},
      '{32'h000000C3, 4'd1, 32'h102, 32'h100, 4'd3, 4'd0, 16'd1},
      '{32'h000000D4, 4'd3, 32'h100, 32'h101, 4'd3, 4'd1, 16'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      cfg_addr = a;
      #1;
      v = cfg_rdata;
   endtask

   task automatic pulse_ev(input logic [31:0] d);
      @(negedge clk);
      ev = 1'b1; ev_data = d;
      @(negedge clk);
      ev = 1'b0;
   endtask

   task automatic ack1();
      @(negedge clk);
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic [3:0]  prev_mid;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 wr_req", {31'b0, wr_req}, 32'd0);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      rd(4'd7, v); chk("R1 status", v, 32'd0);
      rd(4'd8, v); chk("R1 landed", v, 32'd0);
      rd(4'd1, v); chk("R1 size", v, 32'd1);
      rd(4'd2, v); chk("R1 count", v, 32'd0);
      rd(4'd4, v); chk("R1 dest", v, 32'd0);

      // table walk: size 1, 4 elements, ring 0x100..0x103, both enables
      wr(4'd1, 32'd1); wr(4'd2, 32'd4); wr(4'd3, 32'd1);
      wr(4'd5, 32'h100); wr(4'd6, 32'h103); wr(4'd4, 32'h100);
      wr(4'd0, 32'd3);
      prev_mid = 4'd0;
      for (int i = 0; i < 4; i++) begin
         pulse_ev(VECS[i].data);
         chk("R2 req", {31'b0, wr_req}, 32'd1);
         chk("R2 addr", wr_addr, VECS[i].addr);
         chk("R2 data", wr_data, VECS[i].data);
         chk("R2 strb", {28'b0, wr_strb}, 32'h1);
         rd(4'd4, v); chk("R3 R4 dest after issue", v, VECS[i].dst);
         rd(4'd2, v); chk("R3 count after issue", v, {16'b0, VECS[i].cnt});
         rd(4'd7, v); chk("R5 no flag before ack", {28'b0, v[3:0]}, {28'b0, prev_mid});
         for (int k = 0; k < int'(VECS[i].dly); k++) begin
            @(negedge clk);
            chk("R2 held", {31'b0, wr_req}, 32'd1);
         end
         ack1();
         chk("R2 released", {31'b0, wr_req}, 32'd0);
         rd(4'd7, v);
         chk("R5 mid", {28'b0, v[3:0]}, {28'b0, VECS[i].mid});
         chk("R6 fin", {28'b0, v[7:4]}, {28'b0, VECS[i].fin});
         rd(4'd8, v); chk("R8 landed", v, i + 1);
         prev_mid = VECS[i].mid;
      end

      // R13 / R12 masking and write-1-to-clear
      chk("R13 irq both", {31'b0, irq}, 32'd1);
      wr(4'd0, 32'd0);
      chk("R13 irq masked", {31'b0, irq}, 32'd0);
      rd(4'd7, v); chk("R12 kept while masked", v, 32'h13);
      wr(4'd7, 32'h1);
      rd(4'd7, v); chk("R12 clear mid only", v, 32'h10);
      wr(4'd0, 32'd2);
      chk("R13 irq final", {31'b0, irq}, 32'd1);
      wr(4'd7, 32'h2);
      chk("R13 irq after clear", {31'b0, irq}, 32'd0);
      wr(4'd8, 32'd0);
      rd(4'd8, v); chk("R8 landed cleared", v, 32'd0);

      // R9 R10 queue and missed, size 2
      wr(4'd1, 32'd2); wr(4'd2, 32'd3); wr(4'd3, 32'd1);
      wr(4'd5, 32'h200); wr(4'd6, 32'h300); wr(4'd4, 32'h200);
      wr(4'd0, 32'd1);
      pulse_ev(32'h11112222);
      chk("R2 size2 addr", wr_addr, 32'h200);
      chk("R2 size2 strb", {28'b0, wr_strb}, 32'h3);
      pulse_ev(32'h33334444);
      chk("R9 queued not issued", wr_addr, 32'h200);
      rd(4'd4, v); chk("R9 dest only first", v, 32'h202);
      pulse_ev(32'h55556666);
      rd(4'd7, v); chk("R10 missed set", {31'b0, v[8]}, 32'd1);
      ack1();
      chk("R9 queued issued", {31'b0, wr_req}, 32'd1);
      chk("R9 queued addr", wr_addr, 32'h202);
      chk("R9 queued data", wr_data, 32'h33334444);
      rd(4'd7, v); chk("R5 mid after first", {28'b0, v[3:0]}, 32'd1);
      ack1();
      chk("R10 dropped event not issued", {31'b0, wr_req}, 32'd0);
      rd(4'd2, v); chk("R10 count", v, 32'd1);
      pulse_ev(32'h77778888);
      chk("R3 last addr", wr_addr, 32'h204);
      ack1();
      rd(4'd7, v);
      chk("R5 mid final excluded", {28'b0, v[3:0]}, 32'd2);
      chk("R6 fin gated off", {28'b0, v[7:4]}, 32'd0);
      rd(4'd8, v); chk("R8 landed 3", v, 32'd3);

      // R11 ignored event and R12 missed clear
      wr(4'd7, 32'h4);
      rd(4'd7, v); chk("R12 clear missed", {31'b0, v[8]}, 32'd0);
      pulse_ev(32'h99999999);
      chk("R11 no request", {31'b0, wr_req}, 32'd0);
      @(negedge clk);
      chk("R11 still no request", {31'b0, wr_req}, 32'd0);
      rd(4'd4, v); chk("R11 dest unchanged", v, 32'h206);
      rd(4'd7, v); chk("R11 no missed", {31'b0, v[8]}, 32'd0);
      rd(4'd8, v); chk("R11 landed unchanged", v, 32'd3);

      // R7 frames: 2 frames of 2, final only
      wr(4'd7, 32'h7); wr(4'd8, 32'd0);
      wr(4'd1, 32'd1); wr(4'd2, 32'd2); wr(4'd3, 32'd2);
      wr(4'd5, 32'h300); wr(4'd6, 32'h400); wr(4'd4, 32'h300);
      wr(4'd0, 32'd2);
      for (int i = 0; i < 4; i++) begin
         pulse_ev(32'h40 + i);
         if (i == 1) begin
            rd(4'd2, v); chk("R7 count reload", v, 32'd2);
            rd(4'd3, v); chk("R7 frames dec", v, 32'd1);
         end
         ack1();
         rd(4'd7, v);
         chk("R7 fin only at end", {28'b0, v[7:4]}, (i == 3) ? 32'd1 : 32'd0);
      end
      chk("R13 irq frames", {31'b0, irq}, 32'd1);
      rd(4'd2, v); chk("R7 count end", v, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule